// File: doc/BRIEF.md
# Two-Level Table Twiddle Generator

This block turns an angle index k into one complex FFT twiddle factor, the cosine and the sine of 2πk/N. It does not hold one table with a full-resolution entry for every k. It splits the index into a coarse part m, taken from the upper bits, and a fine part n, taken from the lower bits. It reads the coarse angle 2πm/2^C from a coarse sine table and the small residual angle 2πn/N from two fine tables. It then joins the two partial angles with the angle-sum identities. Each of the three tables holds about √N entries, so storage grows with the square root of the transform length and not with N.

The tables are constant ROMs that are computed when the design is elaborated. A single coarse sine table serves both the coarse sine and the coarse cosine: the cosine is read one quarter turn further on. The datapath has four multipliers working side by side, then two adders, then a round-and-saturate stage. A new index can enter on every clock, and each result leaves after a fixed latency of four cycles. An FFT engine drives `in_valid`/`in_idx` beside its butterfly schedule and takes `out_cos`/`out_sin` as signed Q1.15 values.

Top module: `twiddle_lut2`

## Requirements
- R1: The index is split with its upper IDX_W−IDX_W/2 bits as the coarse address m and its lower IDX_W/2 bits as the fine address n, and the result is the twiddle of the full angle 2π(m·2^(IDX_W/2)+n)/2^IDX_W.
- R2: When out_valid is high, out_cos is within 2 LSB of round(cos(2πk/N)·32768) for the index k that entered four cycles earlier, in signed two's complement Q1.15.
- R3: When out_valid is high, out_sin is within 2 LSB of round(sin(2πk/N)·32768) for the same k, with the same Q1.15 encoding.
- R4: For k a multiple of N/4, the outputs are exact: a value of +1.0 saturates to 32767, a value of −1.0 is −32768, and a value of zero is 0 (for example k=0 gives cos 32767 and sin 0, and k=N/4 gives cos 0 and sin 32767).
- R5: out_valid equals in_valid delayed by exactly four clock edges. Cycles with in_valid low produce no valid output, whatever in_idx carries.
- R6: Indices presented on consecutive cycles are all accepted. Each one yields exactly one valid result, in order of arrival.
- R7: A synchronous active-low reset drives out_valid, out_cos and out_sin to 0 and discards indices still in flight, so none of them appears after the reset ends.
- R8: For every valid output, out_cos²+out_sin² lies within 2^18 of 2^30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Index qualifier |
| in_idx | input | IDX_W | Angle index k, angle 2πk/2^IDX_W |
| out_valid | output | 1 | Result qualifier, four cycles after in_valid |
| out_cos | output | OUT_W | Cosine, signed Q1.15 |
| out_sin | output | OUT_W | Sine, signed Q1.15 |

## Verification
The bench covers every index, because a wrong coarse/fine split or a wrong quarter-turn offset for the coarse cosine would damage only some coarse segments. Outputs would then be wrong by whole coarse steps while the values at k=0 still looked right. The four axis points are checked exactly. A design that drops saturation wraps +1.0 to −32768, and one that truncates instead of rounding lands one LSB low on −1.0 or off zero. Bubbled and scattered streams, plus a reset in mid-flight, expose a valid chain whose length does not match the data path, and leftover indices that survive a reset.

// File: rtl/twl_pkg.sv
package twl_pkg;

   localparam real TWO_PI = 6.283185307179586;

   // Latency in cycles: table read, products, sums, round/saturate
   localparam int PIPE_LAT = 4;

   // Quantize a real value to a signed integer with frac fractional bits
   function automatic longint quant(input real v, input int frac);
      real scaled;
      scaled = v * (2.0 ** frac);
      return longint'($floor(scaled + 0.5));
   endfunction

endpackage

// File: rtl/twl_rom.sv
module twl_rom #(
   parameter int ADDR_W = 4,
   parameter int TURN_W = 4,
   parameter int COEF_W = 18,
   parameter bit SINE   = 1'b1,
   parameter int PORTS  = 1
) (
   input  logic                         clk,
   input  logic [PORTS-1:0][ADDR_W-1:0] rd_addr,
   output logic [COEF_W-1:0]            rd_data [PORTS]
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int FRAC  = COEF_W - 2;

   logic [COEF_W-1:0] tbl [DEPTH];

   // Entry i holds the function of angle 2*pi*i/2^TURN_W in Q2.FRAC
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam real ANG = twl_pkg::TWO_PI * real'(i) / real'(longint'(1) << TURN_W);
      localparam real RAW = SINE ? $sin(ANG) : $cos(ANG);
      localparam logic [COEF_W-1:0] QV = COEF_W'(twl_pkg::quant(RAW, FRAC));
      assign tbl[i] = QV;
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
         rd_data[p] <= tbl[rd_addr[p]];
      end
   end

endmodule

// File: rtl/twl_addr.sv
module twl_addr #(
   parameter int IDX_W = 8,
   parameter int CRS_W = 4,
   parameter int FIN_W = 4
) (
   input  logic [IDX_W-1:0] idx,
   output logic [CRS_W-1:0] m_sin,
   output logic [CRS_W-1:0] m_cos,
   output logic [FIN_W-1:0] n
);
   localparam logic [CRS_W-1:0] QTR = CRS_W'(1) << (CRS_W - 2);

   assign m_sin = idx[IDX_W-1 -: CRS_W];
   assign m_cos = m_sin + QTR;
   assign n     = idx[FIN_W-1:0];

endmodule

// File: rtl/twl_rot.sv
module twl_rot #(
   parameter int COEF_W = 18,
   parameter int SUM_W  = 37
) (
   input  logic                    clk,
   input  logic [COEF_W-1:0]       cm,
   input  logic [COEF_W-1:0]       sm,
   input  logic [COEF_W-1:0]       cn,
   input  logic [COEF_W-1:0]       sn,
   output logic signed [SUM_W-1:0] sum_c,
   output logic signed [SUM_W-1:0] sum_s
);
   localparam int PROD_W = 2 * COEF_W;

   logic signed [PROD_W-1:0] p_cc, p_ss, p_sc, p_cs;

   // Stage: four products side by side
   always_ff @(posedge clk) begin
      p_cc <= $signed(cm) * $signed(cn);
      p_ss <= $signed(sm) * $signed(sn);
      p_sc <= $signed(sm) * $signed(cn);
      p_cs <= $signed(cm) * $signed(sn);
   end

   // Stage: angle-sum combination
   always_ff @(posedge clk) begin
      sum_c <= SUM_W'(p_cc) - SUM_W'(p_ss);
      sum_s <= SUM_W'(p_sc) + SUM_W'(p_cs);
   end

endmodule

// File: rtl/twl_round.sv
module twl_round #(
   parameter int IN_W  = 37,
   parameter int SHIFT = 17,
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   localparam int ACC_W = IN_W + 1;
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(longint'(1) << (SHIFT - 1));
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((longint'(1) << (OUT_W - 1)) - 1);
   localparam logic signed [ACC_W-1:0] MINV = -ACC_W'(longint'(1) << (OUT_W - 1));

   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] shifted;
   logic signed [OUT_W-1:0] clipped;

   always_comb begin
      acc     = ACC_W'(din) + HALF;
      shifted = acc >>> SHIFT;
      if (shifted > MAXV)      clipped = MAXV[OUT_W-1:0];
      else if (shifted < MINV) clipped = MINV[OUT_W-1:0];
      else                     clipped = shifted[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) dout <= '0;
      else        dout <= clipped;
   end

endmodule

// File: rtl/twiddle_lut2.sv
module twiddle_lut2 #(
   parameter int IDX_W  = 8,
   parameter int COEF_W = 18,
   parameter int OUT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [IDX_W-1:0]        in_idx,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_cos,
   output logic signed [OUT_W-1:0] out_sin
);
   localparam int FIN_W = IDX_W / 2;
   localparam int CRS_W = IDX_W - FIN_W;
   localparam int FRAC  = COEF_W - 2;
   localparam int SUM_W = 2 * COEF_W + 1;
   localparam int RSH   = 2 * FRAC - (OUT_W - 1);
   localparam int LAT   = twl_pkg::PIPE_LAT;

   // Elaboration-time parameter checks
   if (IDX_W < 4 || IDX_W > 20) begin : g_bad_idx
      $error("twiddle_lut2: IDX_W must lie in 4..20");
   end
   if (OUT_W < 8 || OUT_W > 24) begin : g_bad_out
      $error("twiddle_lut2: OUT_W must lie in 8..24");
   end
   if (COEF_W > 27 || RSH < 1) begin : g_bad_coef
      $error("twiddle_lut2: COEF_W too wide or too narrow for OUT_W");
   end

   logic [CRS_W-1:0] m_sin, m_cos;
   logic [FIN_W-1:0] n;

   twl_addr #(.IDX_W(IDX_W), .CRS_W(CRS_W), .FIN_W(FIN_W)) u_addr (
      .idx   (in_idx),
      .m_sin (m_sin),
      .m_cos (m_cos),
      .n     (n)
   );

   // Coarse sine table, read twice: port 0 sine, port 1 cosine (quarter turn later)
   logic [1:0][CRS_W-1:0] crs_addr;
   logic [COEF_W-1:0]     crs_q [2];
   assign crs_addr[0] = m_sin;
   assign crs_addr[1] = m_cos;

   twl_rom #(.ADDR_W(CRS_W), .TURN_W(CRS_W), .COEF_W(COEF_W), .SINE(1'b1), .PORTS(2)) u_crs (
      .clk     (clk),
      .rd_addr (crs_addr),
      .rd_data (crs_q)
   );

   logic [0:0][FIN_W-1:0] fin_addr;
   logic [COEF_W-1:0]     fcos_q [1];
   logic [COEF_W-1:0]     fsin_q [1];
   assign fin_addr[0] = n;

   twl_rom #(.ADDR_W(FIN_W), .TURN_W(IDX_W), .COEF_W(COEF_W), .SINE(1'b0), .PORTS(1)) u_fcos (
      .clk     (clk),
      .rd_addr (fin_addr),
      .rd_data (fcos_q)
   );

   twl_rom #(.ADDR_W(FIN_W), .TURN_W(IDX_W), .COEF_W(COEF_W), .SINE(1'b1), .PORTS(1)) u_fsin (
      .clk     (clk),
      .rd_addr (fin_addr),
      .rd_data (fsin_q)
   );

   logic signed [SUM_W-1:0] sum_c, sum_s;

   twl_rot #(.COEF_W(COEF_W), .SUM_W(SUM_W)) u_rot (
      .clk   (clk),
      .cm    (crs_q[1]),
      .sm    (crs_q[0]),
      .cn    (fcos_q[0]),
      .sn    (fsin_q[0]),
      .sum_c (sum_c),
      .sum_s (sum_s)
   );

   twl_round #(.IN_W(SUM_W), .SHIFT(RSH), .OUT_W(OUT_W)) u_rnd_c (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sum_c),
      .dout  (out_cos)
   );

   twl_round #(.IN_W(SUM_W), .SHIFT(RSH), .OUT_W(OUT_W)) u_rnd_s (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sum_s),
      .dout  (out_sin)
   );

   // Qualifier chain matching the data path depth
   logic [LAT-1:0] vchain;
   always_ff @(posedge clk) begin
      if (!rst_n) vchain <= '0;
      else        vchain <= {vchain[LAT-2:0], in_valid};
   end
   assign out_valid = vchain[LAT-1];

endmodule

// File: rtl/twl_chk.sv
module twl_chk #(
   parameter int IDX_W = 8,
   parameter int OUT_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [IDX_W-1:0]        in_idx,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] out_cos,
   input logic signed [OUT_W-1:0] out_sin
);
   localparam logic [IDX_W-1:0] QTR_IDX = IDX_W'(1) << (IDX_W - 2);
   localparam logic signed [OUT_W-1:0] POS1 = OUT_W'((longint'(1) << (OUT_W - 1)) - 1);
   localparam longint UNIT = longint'(1) << (2 * (OUT_W - 1));
   localparam longint SLACK = longint'(1) << (2 * (OUT_W - 1) - 12);

   int unsigned since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)             since_rst <= 0;
      else if (since_rst < 8) since_rst <= since_rst + 1;
   end

   longint norm;
   assign norm = longint'(out_cos) * longint'(out_cos) + longint'(out_sin) * longint'(out_sin);

   // R5
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4) |-> (out_valid == $past(in_valid, 4)));

   // R4
   origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4 && $past(in_valid && in_idx == '0, 4)) |-> (out_cos == POS1 && out_sin == '0));

   // R4
   quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4 && $past(in_valid && in_idx == QTR_IDX, 4)) |-> (out_cos == '0 && out_sin == POS1));

   // R8
   unit_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (norm > UNIT - SLACK && norm < UNIT + SLACK));

endmodule

bind twiddle_lut2 twl_chk #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_idx    (in_idx),
   .out_valid (out_valid),
   .out_cos   (out_cos),
   .out_sin   (out_sin)
);

// File: tb/twiddle_lut2_bench.sv
module twiddle_lut2_bench;
   localparam int IDX_W = 8;
   localparam int OUT_W = 16;
   localparam int N     = 1 << IDX_W;
   localparam int LAT   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [IDX_W-1:0] in_idx = '0;
   logic out_valid;
   logic signed [OUT_W-1:0] out_cos, out_sin;

   always #5 clk = ~clk;

   twiddle_lut2 #(.IDX_W(IDX_W), .COEF_W(18), .OUT_W(OUT_W)) u_twiddle_lut2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_idx    (in_idx),
      .out_valid (out_valid),
      .out_cos   (out_cos),
      .out_sin   (out_sin)
   );

   int n_chk = 0;
   int n_bad = 0;
   int n_out = 0;
   bit done  = 1'b0;
   bit hv [LAT];
   int hk [LAT];

   function automatic int ref_val(input int k, input bit sine);
      real a, v;
      int r;
      a = 6.283185307179586 * real'(k) / real'(N);
      v = sine ? $sin(a) : $cos(a);
      r = int'($floor(v * 32768.0 + 0.5));
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Output monitor: expected qualifier is the input seen four edges back
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) begin hv[i] = 1'b0; hk[i] = 0; end
      end else begin
         for (int i = LAT - 1; i > 0; i--) begin hv[i] = hv[i-1]; hk[i] = hk[i-1]; end
         hv[0] = in_valid;
         hk[0] = int'(in_idx);
      end
      #2;
      if (rst_n) begin
         check(out_valid === hv[LAT-1], "R5", "out_valid", longint'(out_valid), longint'(hv[LAT-1]));
         if (hv[LAT-1] && out_valid === 1'b1) begin
            int k, ec, es, dc, ds;
            longint nrm;
            n_out++;
            k  = hk[LAT-1];
            ec = ref_val(k, 1'b0);
            es = ref_val(k, 1'b1);
            dc = int'(out_cos) - ec;
            ds = int'(out_sin) - es;
            if (k % (N / 4) == 0) begin
               check(dc == 0, "R4", $sformatf("cos k=%0d", k), out_cos, ec);
               check(ds == 0, "R4", $sformatf("sin k=%0d", k), out_sin, es);
            end
            check(dc >= -2 && dc <= 2, "R2", $sformatf("cos k=%0d", k), out_cos, ec);
            check(ds >= -2 && ds <= 2, "R3", $sformatf("sin k=%0d", k), out_sin, es);
            nrm = longint'(out_cos) * out_cos + longint'(out_sin) * out_sin;
            check(nrm > (64'd1 << 30) - (64'd1 << 18) && nrm < (64'd1 << 30) + (64'd1 << 18),
                  "R8", $sformatf("norm k=%0d", k), nrm, 64'd1 << 30);
         end
      end
   end

   task automatic drive(input bit v, input int k);
      @(negedge clk);
      in_valid = v;
      in_idx   = IDX_W'(k);
   endtask

   task automatic drain();
      for (int i = 0; i < LAT + 2; i++) drive(1'b0, 0);
   endtask

   // R7: reset with a live input stream holds outputs at zero
   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b1; in_idx = IDX_W'(5);
      repeat (4) @(negedge clk);
      check(out_valid === 1'b0, "R7", "out_valid in reset", longint'(out_valid), 0);
      check(out_cos === '0, "R7", "out_cos in reset", out_cos, 0);
      check(out_sin === '0, "R7", "out_sin in reset", out_sin, 0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      drain();
   endtask

   // R1, R2, R3, R6: every index back to back
   task automatic t_sweep();
      int base = n_out;
      for (int k = 0; k < N; k++) drive(1'b1, k);
      drain();
      check(n_out - base == N, "R6", "results from full sweep", n_out - base, N);
   endtask

   // R1, R5: scattered indices with bubbles, fine field all ones at k=N-1
   task automatic t_scatter();
      int base = n_out;
      int sent = 0;
      for (int i = 0; i < 90; i++) begin
         if (i % 3 == 2) drive(1'b0, (i * 91) % N);
         else begin
            drive(1'b1, (i * 37 + 11) % N);
            sent++;
         end
      end
      drive(1'b1, N - 1); sent++;
      drain();
      check(n_out - base == sent, "R5", "results from bubbled stream", n_out - base, sent);
   endtask

   // R4: axis points back to back
   task automatic t_corners();
      int base = n_out;
      drive(1'b1, 0);
      drive(1'b1, N / 4);
      drive(1'b1, N / 2);
      drive(1'b1, 3 * N / 4);
      drive(1'b1, 0);
      drain();
      check(n_out - base == 5, "R4", "axis results", n_out - base, 5);
   endtask

   // R5: idle cycles with a busy index bus give nothing
   task automatic t_idle();
      int base = n_out;
      for (int i = 0; i < 12; i++) drive(1'b0, i * 19);
      drain();
      check(n_out - base == 0, "R5", "results while idle", n_out - base, 0);
   endtask

   // R7: reset in mid-flight discards pending indices
   task automatic t_reset_mid();
      int base;
      drive(1'b1, 7);
      drive(1'b1, 8);
      drive(1'b1, 9);
      base = n_out;
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      check(out_valid === 1'b0, "R7", "out_valid after mid reset", longint'(out_valid), 0);
      check(out_cos === '0 && out_sin === '0, "R7", "out_cos after mid reset", out_cos, 0);
      rst_n = 1'b1;
      drain();
      drain();
      check(n_out - base == 0, "R7", "results leaking past reset", n_out - base, 0);
   endtask

   initial begin
      t_reset();
      t_sweep();
      t_scatter();
      t_corners();
      t_idle();
      t_reset_mid();
      t_sweep();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

endmodule